// File: doc/BRIEF.md
# Register-Read Target on a Two-Wire Serial Bus

This block is the target side of an I2C link that sits in front of a register file. It watches the clock and data lines and recognises the start, repeated-start and stop conditions. It accepts a write-direction address byte naming it, then a one-byte register pointer. After a repeated start and a read-direction address byte, it returns register contents one byte after another until the controller declines a byte.

The pointer is checked against a configurable inclusive window. A pointer outside that window is refused in its acknowledge slot. During a read, the pointer advances after every byte sent, so a burst walks consecutive addresses. Register contents come through a one-cycle synchronous read port, so the register file itself stays outside the block. The data line is driven only as an open-drain pull-down enable. Both bus lines pass through a synchroniser before any decoding.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (data line falling while the clock line is high) begins reception of an address byte from any state, including part-way through a byte. A STOP (data line rising while the clock line is high) returns the block to idle with the data line released.
- R2: The address byte arrives most significant bit first: seven address bits, then the direction bit (0 = write, 1 = read). When the seven bits equal `DEV_ADDR`, the block pulls the data line low for the whole ninth clock pulse (ACK). Otherwise it leaves the line high (NACK) and ignores the bus until the next START.
- R3: After a write-direction address, the next byte is a register pointer. If it lies within `REG_LO`..`REG_HI` inclusive, it is ACKed and stored. Otherwise it is NACKed, and the block ignores the bus until the next START.
- R4: Further bytes written after an accepted pointer are not acknowledged.
- R5: A read-direction address that matches is ACKed. The block then sends the register byte at the stored pointer, most significant bit first, one bit per clock pulse.
- R6: The pointer increases by one (modulo 256) after every byte sent. After a controller ACK, the next byte comes from the next address. The pointer is kept across a repeated START, and the increment is not limited by the pointer window.
- R7: When the controller NACKs a read byte, the block releases the data line and drives nothing more until the next START.
- R8: The data-line drive changes only while the clock line is low.
- R9: `reg_rd_en_o` is a single-cycle pulse with `reg_rd_addr_o` valid in that cycle. `reg_rd_data_i` is taken on the following cycle.
- R10: While reset is asserted, and directly after it, `sda_oe_o` and `reg_rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low |
| reg_rd_en_o | output | 1 | Register read strobe |
| reg_rd_addr_o | output | 8 | Register read address |
| reg_rd_data_i | input | 8 | Register data, valid the cycle after the strobe |

## Verification
The hardest situation to reach is the pointer carrying over: a burst that ends with a controller NACK, followed by a repeated START with no STOP in between, must resume at the address after the NACKed byte. A bench task makes this happen. It reads across the upper window edge, NACKs, then issues a repeated START straight into a second read and checks the address continuity. Other tasks abort a byte with a STOP part-way through and probe the NACK paths. After each refusal the probe clocks out one more byte and confirms that the data line stays high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    // bus idles high, so reset to ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;
      else         pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter logic [7:0] REG_LO      = 8'h02,
  parameter logic [7:0] REG_HI      = 8'h7F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              reg_rd_en_o,
  output logic [BYTE_W-1:0] reg_rd_addr_o,
  input  logic [BYTE_W-1:0] reg_rd_data_i
);
  localparam int                CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, ev_start, ev_stop;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_bus_events i_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (ev_start),
    .stop_o    (ev_stop)
  );

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, ptr;
  logic              rd_dir, ctl_ack, load_pend;
  logic              addr_hit, reg_ok;

  assign addr_hit = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
  assign reg_ok   = (rx_sh >= REG_LO) && (rx_sh <= REG_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      rx_sh         <= '0;
      tx_sh         <= '0;
      ptr           <= '0;
      rd_dir        <= 1'b0;
      ctl_ack       <= 1'b0;
      load_pend     <= 1'b0;
      sda_oe_o      <= 1'b0;
      reg_rd_en_o   <= 1'b0;
      reg_rd_addr_o <= '0;
    end else begin
      reg_rd_en_o <= 1'b0;
      load_pend   <= reg_rd_en_o;
      if (load_pend) tx_sh <= reg_rd_data_i;

      if (ev_stop) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (ev_start) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_REG: begin
            if (scl_rise && bit_cnt != CNT_FULL) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_FULL) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe_o <= 1'b1;
                  rd_dir   <= rx_sh[0];
                  state    <= ST_ADDR_ACK;
                  if (rx_sh[0]) begin
                    reg_rd_en_o   <= 1'b1;
                    reg_rd_addr_o <= ptr;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else if (reg_ok) begin
                ptr      <= rx_sh;
                sda_oe_o <= 1'b1;
                state    <= ST_REG_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                sda_oe_o <= ~tx_sh[BYTE_W-1];
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_REG;
              end
            end
          end
          ST_REG_ACK: begin
            // data bytes after the pointer are left unacknowledged
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              state    <= ST_IDLE;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == CNT_LAST) begin
                sda_oe_o      <= 1'b0;
                ptr           <= ptr + 1'b1;
                reg_rd_en_o   <= 1'b1;
                reg_rd_addr_o <= ptr + 1'b1;
                state         <= ST_TX_ACK;
              end else begin
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~tx_sh[BYTE_W-2];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) ctl_ack <= ~sda_s;
            if (scl_fall) begin
              if (ctl_ack) begin
                bit_cnt  <= '0;
                sda_oe_o <= ~tx_sh[BYTE_W-1];
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_oe_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  assert_start_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_start && !ev_stop) |=> (state == ST_ADDR && bit_cnt == '0));

  assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop |=> (state == ST_IDLE && !sda_oe_o));

  assert_rd_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_en_o |=> !reg_rd_en_o);

  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_en_o && $past(state) == ST_TX) |-> reg_rd_addr_o == $past(reg_rd_addr_o) + 1'b1);

  assert_ptr_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_REG_ACK) |-> (ptr >= REG_LO && ptr <= REG_HI));
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe, rd_en;
  logic [7:0] rd_addr, rd_data;
  wire  sda_line = ~(m_low | sda_oe);

  int total = 0, bad = 0, oe_viol = 0, long_rd = 0;
  logic oe_prev = 1'b0, rd_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_rd_en_o(rd_en), .reg_rd_addr_o(rd_addr),
    .reg_rd_data_i(rd_data)
  );

  function automatic logic [7:0] reg_val(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= reg_val(rd_addr);

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl) oe_viol++;
    if (rst_n && rd_en && rd_prev) long_rd++;
    oe_prev = sda_oe;
    rd_prev = rd_en;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    chk("R10 oe", sda_oe, 1'b0);
    chk("R10 rd_en", rd_en, 1'b0);
    chk("R10 line", sda_line, 1'b1);
  endtask

  task automatic t_burst();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1'b1);
    put_byte(8'h10, a);       chk("R3 ptr ack", a, 1'b1);
    bus_start();
    put_byte({DEV, 1'b1}, a); chk("R5 read addr ack", a, 1'b1);
    for (int k = 0; k < 4; k++) begin
      get_byte(k != 3, d);
      chk("R5 R6 burst byte", d, reg_val(8'(8'h10 + k)));
    end
    get_byte(1'b0, d); chk("R7 released after nack", d, 8'hFF);
    bus_stop();
    chk("R1 stop releases", sda_oe, 1'b0);
  endtask

  task automatic t_window_edge();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1'b1);
    put_byte(8'h7F, a);       chk("R3 upper edge ack", a, 1'b1);
    bus_start();
    put_byte({DEV, 1'b1}, a); chk("R5 read ack", a, 1'b1);
    get_byte(1'b1, d); chk("R6 byte 7F", d, reg_val(8'h7F));
    get_byte(1'b0, d); chk("R6 byte 80 past window", d, reg_val(8'h80));
    bus_start();
    put_byte({DEV, 1'b1}, a); chk("R6 rstart read ack", a, 1'b1);
    get_byte(1'b0, d); chk("R6 pointer kept over rstart", d, reg_val(8'h81));
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    put_byte({DEV ^ 7'h01, 1'b0}, a); chk("R2 mismatch nack", a, 1'b0);
    put_byte(8'h10, a);               chk("R2 ignored after mismatch", a, 1'b0);
    bus_stop();
  endtask

  task automatic t_bad_ptr();
    logic a;
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1'b1);
    put_byte(8'h80, a);       chk("R3 above window nack", a, 1'b0);
    put_byte(8'h10, a);       chk("R3 ignored after nack", a, 1'b0);
    bus_stop();
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1'b1);
    put_byte(8'h01, a);       chk("R3 below window nack", a, 1'b0);
    bus_stop();
  endtask

  task automatic t_write_data();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", a, 1'b1);
    put_byte(8'h02, a);       chk("R3 lower edge ack", a, 1'b1);
    put_byte(8'h5A, a);       chk("R4 data byte nack", a, 1'b0);
    bus_start();
    put_byte({DEV, 1'b1}, a); chk("R5 read ack", a, 1'b1);
    get_byte(1'b0, d);        chk("R5 byte at 02", d, reg_val(8'h02));
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    bus_start();
    put_bit(1'b1); put_bit(1'b1);
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R1 start after aborts", a, 1'b1);
    bus_stop();
  endtask

  initial begin
    wq(5);
    t_reset();
    rst_n = 1'b1;
    wq(3);
    t_reset();
    t_burst();
    t_window_edge();
    t_mismatch();
    t_bad_ptr();
    t_write_data();
    t_abort();
    chk("R8 drive changes with scl low", oe_viol, 0);
    chk("R9 single-cycle strobe", long_rd, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule